// File: doc/BRIEF.md
# DMA Channel Burst Address Sequencer

This block is the address and length engine of one channel of a descriptor-style DMA controller. Software loads a source address, a target address, a command word and an alignment-enable bit through a small write port. A start pulse checks the programmed combination. If the combination is legal, the channel runs. It issues one burst request at a time on a request/grant interface, and each burst carries a source address, a target address and a byte count. After every granted burst, the remaining length falls by that burst's bytes. Each address then advances if its increment bit allows it.

When flow control is selected for either side, a burst is requested only while the peripheral request line is high. Low address bits are cleared on the bus by default: three bits on the memory side and two bits on a peripheral side. The alignment-enable bit turns this clearing off. A channel that finishes its length gives a single-cycle done pulse and sets a sticky end flag. A stop request ends the run at the next burst boundary. An illegal configuration raises an error flag and the channel does not start.

The command word is written with select 2. Its fields are: bits 12:0 byte length, bits 14:13 width, bits 16:15 burst code, bit 17 source increment, bit 18 target increment, bit 19 source flow control, bit 20 target flow control, bit 21 source fly-by, bit 22 target fly-by, and bit 23 companion-device mode. Select 0 writes the source address, select 1 writes the target address, and select 3 writes the alignment enable in bit 0.

Top module: `dma_burst_seq`

## Requirements
- R1: After a granted burst (bus_req and bus_gnt high at a clock edge), the source address advances by that burst's byte count only if command bit 17 is set. The target address advances only if command bit 18 is set. Otherwise the address stays the same.
- R2: Burst code 01, 10 or 11 (command bits 16:15) selects 8, 16 or 32 bytes. Each burst's bus_len is the smaller of that size and the remaining length, and the remaining length falls by bus_len after each grant.
- R3: With alignment disabled, a memory-side address is driven with bits 2:0 at zero. A side is the memory side when its flow-control bit is clear.
- R4: With alignment disabled, a peripheral-side address is driven with bits 1:0 at zero. A side is the peripheral side when its flow-control bit (19 for source, 20 for target) is set.
- R5: With the alignment enable (select 3, bit 0) set, both addresses are driven exactly as held, with no bits cleared.
- R6: A nonzero width (command bits 14:13) is an error when neither flow-control bit is set or when companion mode (bit 23) is set. With a flow-control bit set and companion mode clear, a nonzero width is accepted.
- R7: In companion mode, a source or target address whose bits 2:0 are not zero is an error.
- R8: While either flow-control bit is set and periph_req is low, no burst is requested and the channel keeps running.
- R9: A set fly-by bit (command bit 21 or 22) is an error.
- R10: When the remaining length reaches zero, running falls, done is high for exactly one cycle, and end_flag becomes 1. end_flag stays 1 until the next accepted start clears it.
- R11: A stop pulse never drops a burst request that has not been granted. The channel goes idle after the current burst is granted, without a done pulse.
- R12: Configuration writes are ignored while running is high.
- R13: Burst code 00 or a byte length of 0 is an error. On any error, a start sets cfg_err, and the channel stays idle with no burst requested. An accepted start clears cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 target, 2 command, 3 alignment |
| cfg_wdata | input | ADDR_W | Configuration write data |
| start | input | 1 | Start pulse, honoured while idle |
| stop | input | 1 | Stop request, honoured at a burst boundary |
| periph_req | input | 1 | Peripheral request used for flow control |
| bus_req | output | 1 | Burst request |
| bus_gnt | input | 1 | Burst grant; a burst completes when request and grant are both high |
| bus_src_addr | output | ADDR_W | Source address of the current burst |
| bus_trg_addr | output | ADDR_W | Target address of the current burst |
| bus_len | output | 13 | Byte count of the current burst |
| running | output | 1 | Channel run state |
| done | output | 1 | One-cycle pulse when the full length has been moved |
| end_flag | output | 1 | Sticky end-of-transfer flag |
| cfg_err | output | 1 | Configuration error from the last start attempt |

## Verification
The bench drives a length that does not divide evenly by the burst size. A design that always used the full burst size would show up with a wrong last bus_len and extra bursts. Unaligned addresses are run with and without the alignment enable, and with each side acting as a peripheral. A design that cleared the wrong number of low bits, or cleared bits while byte alignment was enabled, would produce address mismatches. It also runs a transfer with the source increment off, which a design that always advanced both addresses would get wrong.

A stop arrives while a burst is still waiting for its grant. A design that abandoned the request, or raised done on a stopped run, is caught. A source register write during that run is followed by a restart, which exposes a missing write lock. Each error rule is tested with a start that must neither run nor request a burst. Legal neighbours of each rule are also run: nonzero width with flow control, and a companion transfer with aligned addresses. These expose a design that rejected too much.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int LEN_W   = 13;
    localparam int BURST_W = 6;

    typedef enum logic [1:0] {
        SEL_SRC   = 2'd0,
        SEL_TRG   = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_ALIGN = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic             companion;
        logic             flyby_trg;
        logic             flyby_src;
        logic             flow_trg;
        logic             flow_src;
        logic             inc_trg;
        logic             inc_src;
        logic [1:0]       burst;
        logic [1:0]       width;
        logic [LEN_W-1:0] len;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_REQ  = 2'd2
    } st_e;

    function automatic logic [BURST_W-1:0] burst_bytes(input logic [1:0] code);
        case (code)
            2'b01:   return BURST_W'(8);
            2'b10:   return BURST_W'(16);
            2'b11:   return BURST_W'(32);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              lock,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] trg_q,
    output cmd_t              cmd_q,
    output logic              align_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            trg_q   <= '0;
            cmd_q   <= '0;
            align_q <= 1'b0;
        end else if (we && !lock) begin
            case (cfg_sel_e'(sel))
                SEL_SRC:   src_q   <= wdata;
                SEL_TRG:   trg_q   <= wdata;
                SEL_CMD:   cmd_q   <= cmd_t'(wdata[CMD_W-1:0]);
                SEL_ALIGN: align_q <= wdata[0];
                default:   ;
            endcase
        end
    end

    // R12: registers hold while the channel runs
    a_r12_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(src_q) && $stable(trg_q) && $stable(cmd_q) && $stable(align_q)));

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_seq_pkg::*;
(
    input  logic             flow_src,
    input  logic             flow_trg,
    input  logic             flyby_src,
    input  logic             flyby_trg,
    input  logic             companion,
    input  logic [1:0]       width,
    input  logic [1:0]       burst,
    input  logic [LEN_W-1:0] len,
    input  logic [2:0]       src_lo,
    input  logic [2:0]       trg_lo,
    output logic             bad
);

    logic mem_only;
    logic width_bad;
    logic flyby_bad;
    logic comp_bad;
    logic shape_bad;

    always_comb begin
        mem_only  = !flow_src && !flow_trg;
        width_bad = (width != 2'b00) && (mem_only || companion);
        flyby_bad = flyby_src || flyby_trg;
        comp_bad  = companion && ((src_lo != 3'd0) || (trg_lo != 3'd0));
        shape_bad = (burst == 2'b00) || (len == '0);
        bad       = width_bad || flyby_bad || comp_bad || shape_bad;
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] trg_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [1:0]        burst,
    input  logic              inc_src,
    input  logic              inc_trg,
    input  logic              src_periph,
    input  logic              trg_periph,
    input  logic              align_en,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_trg,
    output logic [LEN_W-1:0]  step,
    output logic              last
);

    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_trg;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  bb_ext;

    function automatic logic [ADDR_W-1:0] pin_low(input logic [ADDR_W-1:0] a,
                                                  input logic periph,
                                                  input logic al);
        logic [ADDR_W-1:0] mask;
        mask = al ? '0 : (periph ? ADDR_W'(3) : ADDR_W'(7));
        return a & ~mask;
    endfunction

    always_comb begin
        bb_ext  = LEN_W'(burst_bytes(burst));
        step    = (rem < bb_ext) ? rem : bb_ext;
        last    = (rem <= bb_ext);
        bus_src = pin_low(cur_src, src_periph, align_en);
        bus_trg = pin_low(cur_trg, trg_periph, align_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_src <= '0;
            cur_trg <= '0;
            rem     <= '0;
        end else if (load) begin
            cur_src <= src_in;
            cur_trg <= trg_in;
            rem     <= len_in;
        end else if (adv) begin
            rem <= rem - step;
            if (inc_src) cur_src <= cur_src + ADDR_W'(step);
            if (inc_trg) cur_trg <= cur_trg + ADDR_W'(step);
        end
    end

    // R2: a granted burst is never empty and never exceeds the burst size
    a_r2_step_bounded: assert property (@(posedge clk) disable iff (rst)
        adv |-> (step != '0 && step <= bb_ext));

    // R2: the remaining length drops by exactly the burst count
    a_r2_rem_down: assert property (@(posedge clk) disable iff (rst)
        adv |=> (rem == $past(rem) - $past(step)));

    // R1: without the increment bit the source address stays put
    a_r1_src_hold: assert property (@(posedge clk) disable iff (rst)
        (adv && !inc_src) |=> $stable(cur_src));

    // R1: without the increment bit the target address stays put
    a_r1_trg_hold: assert property (@(posedge clk) disable iff (rst)
        (adv && !inc_trg) |=> $stable(cur_trg));

    // R3: memory-side source address carries zero low bits unless aligned mode
    a_r3_mem_low_zero: assert property (@(posedge clk) disable iff (rst)
        (!align_en && !src_periph) |-> (bus_src[2:0] == 3'd0));

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              periph_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_src_addr,
    output logic [ADDR_W-1:0] bus_trg_addr,
    output logic [LEN_W-1:0]  bus_len,
    output logic              running,
    output logic              done,
    output logic              end_flag,
    output logic              cfg_err
);

    st_e               state;
    logic              stop_pend;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] trg_q;
    cmd_t              cmd_q;
    logic              align_q;
    logic              cfg_bad;
    logic              need_flow;
    logic              gate_ok;
    logic              fire;
    logic              last;
    logic              load;

    assign running   = (state != ST_IDLE);
    assign bus_req   = (state == ST_REQ);
    assign fire      = bus_req && bus_gnt;
    assign need_flow = cmd_q.flow_src || cmd_q.flow_trg;
    assign gate_ok   = !need_flow || periph_req;
    assign load      = (state == ST_IDLE) && start && !cfg_bad;

    dma_cfg_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .lock    (running),
        .src_q   (src_q),
        .trg_q   (trg_q),
        .cmd_q   (cmd_q),
        .align_q (align_q)
    );

    dma_cfg_check check_i (
        .flow_src  (cmd_q.flow_src),
        .flow_trg  (cmd_q.flow_trg),
        .flyby_src (cmd_q.flyby_src),
        .flyby_trg (cmd_q.flyby_trg),
        .companion (cmd_q.companion),
        .width     (cmd_q.width),
        .burst     (cmd_q.burst),
        .len       (cmd_q.len),
        .src_lo    (src_q[2:0]),
        .trg_lo    (trg_q[2:0]),
        .bad       (cfg_bad)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv        (fire),
        .src_in     (src_q),
        .trg_in     (trg_q),
        .len_in     (cmd_q.len),
        .burst      (cmd_q.burst),
        .inc_src    (cmd_q.inc_src),
        .inc_trg    (cmd_q.inc_trg),
        .src_periph (cmd_q.flow_src),
        .trg_periph (cmd_q.flow_trg),
        .align_en   (align_q),
        .bus_src    (bus_src_addr),
        .bus_trg    (bus_trg_addr),
        .step       (bus_len),
        .last       (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
            done      <= 1'b0;
            end_flag  <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (running && stop) stop_pend <= 1'b1;
            case (state)
                ST_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start) begin
                        if (cfg_bad) begin
                            cfg_err <= 1'b1;
                        end else begin
                            cfg_err  <= 1'b0;
                            end_flag <= 1'b0;
                            state    <= ST_GATE;
                        end
                    end
                end
                ST_GATE: begin
                    if (stop_pend || stop) begin
                        state     <= ST_IDLE;
                        stop_pend <= 1'b0;
                    end else if (gate_ok) begin
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (fire) begin
                        if (last) begin
                            state     <= ST_IDLE;
                            stop_pend <= 1'b0;
                            done      <= 1'b1;
                            end_flag  <= 1'b1;
                        end else begin
                            state <= ST_GATE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done coincides with the channel having stopped running
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!running && end_flag));

    // R8: no request while flow control waits on the peripheral
    a_r8_flow_gate: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GATE && need_flow && !periph_req) |=> !bus_req);

    // R11: an ungranted request is never withdrawn
    a_r11_req_holds: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);

    // R13: a rejected start leaves the channel idle with the error raised
    a_r13_err_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && cfg_bad) |=> (!running && cfg_err));

endmodule

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb_top;

    localparam int AW = 32;
    localparam int LW = 13;

    typedef struct packed {
        logic [AW-1:0] s;
        logic [AW-1:0] t;
        logic [LW-1:0] l;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          periph_req = 1'b0;
    logic          bus_req;
    logic          bus_gnt;
    logic [AW-1:0] bus_src_addr;
    logic [AW-1:0] bus_trg_addr;
    logic [LW-1:0] bus_len;
    logic          running;
    logic          done;
    logic          end_flag;
    logic          cfg_err;

    logic gnt_auto = 1'b1;
    logic gnt_force = 1'b0;
    logic gnt_pat = 1'b0;
    int   cyc = 0;

    int n_checks = 0;
    int n_fail = 0;
    int done_cnt = 0;
    logic prev_done = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    assign bus_gnt = gnt_auto ? gnt_pat : gnt_force;

    dma_burst_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .stop(stop),
        .periph_req(periph_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_src_addr(bus_src_addr), .bus_trg_addr(bus_trg_addr),
        .bus_len(bus_len), .running(running), .done(done),
        .end_flag(end_flag), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // grant pattern: two of every three cycles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            gnt_pat = (cyc % 3) != 1;
        end
    end

    // monitor: pops expected bursts as they are granted
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                done_cnt++;
                chk(!prev_done, "R10", "done wider than one cycle", 1, 0);
            end
            prev_done = done;
            if (bus_req && bus_gnt) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R13", "unexpected burst src", bus_src_addr, 0);
                end else begin
                    exp_t  e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(bus_src_addr == e.s, tg, "burst src", bus_src_addr, e.s);
                    chk(bus_trg_addr == e.t, tg, "burst trg", bus_trg_addr, e.t);
                    chk(bus_len == e.l, tg, "burst len", bus_len, e.l);
                end
            end
        end
    end

    function automatic logic [AW-1:0] mk_cmd(input int len, input int width, input int burst,
                                             input bit inc_s, input bit inc_t,
                                             input bit fl_s, input bit fl_t,
                                             input bit fb_s, input bit fb_t, input bit comp);
        logic [AW-1:0] c;
        c = '0;
        c[12:0]  = len[12:0];
        c[14:13] = width[1:0];
        c[16:15] = burst[1:0];
        c[17] = inc_s;
        c[18] = inc_t;
        c[19] = fl_s;
        c[20] = fl_t;
        c[21] = fb_s;
        c[22] = fb_t;
        c[23] = comp;
        return c;
    endfunction

    function automatic logic [AW-1:0] clr(input logic [AW-1:0] a, input bit periph, input bit al);
        if (al) return a;
        if (periph) return {a[AW-1:2], 2'b00};
        return {a[AW-1:3], 3'b000};
    endfunction

    // driver side of the scoreboard: expected burst list from the requirements
    task automatic push_bursts(input logic [AW-1:0] src, input logic [AW-1:0] trg,
                               input int len, input int bsize, input bit inc_s, input bit inc_t,
                               input bit ps, input bit pt, input bit al, input string tag);
        int rem;
        rem = len;
        while (rem > 0) begin
            int   st;
            exp_t e;
            st  = (rem < bsize) ? rem : bsize;
            e.s = clr(src, ps, al);
            e.t = clr(trg, pt, al);
            e.l = LW'(st);
            exp_q.push_back(e);
            tag_q.push_back(tag);
            if (inc_s) src = src + AW'(st);
            if (inc_t) trg = trg + AW'(st);
            rem -= st;
        end
    endtask

    task automatic wr(input int sel, input logic [AW-1:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_all(input logic [AW-1:0] s, input logic [AW-1:0] t,
                           input logic [AW-1:0] c, input bit al);
        wr(0, s); wr(1, t); wr(2, c); wr(3, {31'd0, al});
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic run_ok(input string tag);
        int n;
        int d0;
        d0 = done_cnt;
        pulse_start();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (running && n < 4000);
        repeat (2) @(negedge clk);
        chk(!running, tag, "channel still running", running, 0);
        chk(exp_q.size() == 0, tag, "bursts missing", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R10", "done pulse count", done_cnt - d0, 1);
        chk(end_flag && !cfg_err, "R10", "end_flag/cfg_err after run",
            {end_flag, cfg_err}, 2'b10);
    endtask

    task automatic run_err(input string tag);
        pulse_start();
        repeat (3) @(negedge clk);
        chk(cfg_err && !running && !bus_req, tag, "rejected start {err,run,req}",
            {cfg_err, running, bus_req}, 3'b100);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({bus_req, running, done, end_flag, cfg_err} == 5'b0, "R10", "reset outputs",
            {bus_req, running, done, end_flag, cfg_err}, 0);

        // R2 R3: uneven length, 32-byte bursts, memory sides with low bits cleared
        cfg_all(32'h1000_0005, 32'h2000_0003, mk_cmd(100, 0, 3, 1, 1, 0, 0, 0, 0, 0), 1'b0);
        push_bursts(32'h1000_0005, 32'h2000_0003, 100, 32, 1, 1, 0, 0, 0, "R2/R3");
        run_ok("R2");

        // R1: source fixed, target increments, 8-byte bursts
        cfg_all(32'h3000_0000, 32'h3100_0010, mk_cmd(20, 0, 1, 0, 1, 0, 0, 0, 0, 0), 1'b0);
        push_bursts(32'h3000_0000, 32'h3100_0010, 20, 8, 0, 1, 0, 0, 0, "R1");
        run_ok("R1");

        // R5: byte alignment enabled, no bits cleared
        cfg_all(32'h0000_1003, 32'h0000_2001, mk_cmd(40, 0, 2, 1, 1, 0, 0, 0, 0, 0), 1'b1);
        push_bursts(32'h0000_1003, 32'h0000_2001, 40, 16, 1, 1, 0, 0, 1, "R5");
        run_ok("R5");

        // R8 R4: target flow control gates bursts, peripheral target clears two bits
        periph_req = 1'b0;
        cfg_all(32'h5000_0006, 32'h4000_0003, mk_cmd(24, 0, 1, 1, 0, 0, 1, 0, 0, 0), 1'b0);
        push_bursts(32'h5000_0006, 32'h4000_0003, 24, 8, 1, 0, 0, 1, 0, "R4/R8");
        begin
            int d0;
            int n;
            d0 = done_cnt;
            pulse_start();
            repeat (8) @(negedge clk);
            chk(running && !bus_req, "R8", "gated {run,req}", {running, bus_req}, 2'b10);
            @(posedge clk); #1 periph_req = 1'b1;
            n = 0;
            do begin @(negedge clk); n++; end while (running && n < 4000);
            repeat (2) @(negedge clk);
            chk(exp_q.size() == 0 && done_cnt == d0 + 1, "R8", "flow run completion",
                exp_q.size(), 0);
        end

        // R6: nonzero width accepted with source flow control
        cfg_all(32'h4000_0007, 32'h6000_0000, mk_cmd(16, 2, 2, 0, 1, 1, 0, 0, 0, 0), 1'b0);
        push_bursts(32'h4000_0007, 32'h6000_0000, 16, 16, 0, 1, 1, 0, 0, "R6/R4");
        run_ok("R6");
        periph_req = 1'b0;

        // R6: nonzero width rejected for memory-to-memory
        cfg_all(32'h1000_0000, 32'h2000_0000, mk_cmd(16, 1, 1, 1, 1, 0, 0, 0, 0, 0), 1'b0);
        run_err("R6");

        // R7: companion with misaligned source rejected
        cfg_all(32'h0000_1004, 32'h0000_2008, mk_cmd(24, 0, 2, 1, 1, 0, 0, 0, 0, 1), 1'b0);
        run_err("R7");
        // R7: companion with aligned addresses runs, R13 error cleared
        wr(0, 32'h0000_1000);
        push_bursts(32'h0000_1000, 32'h0000_2008, 24, 16, 1, 1, 0, 0, 0, "R7");
        run_ok("R7");

        // R9: fly-by bits rejected
        cfg_all(32'h1000_0000, 32'h2000_0000, mk_cmd(16, 0, 1, 1, 1, 0, 0, 1, 0, 0), 1'b0);
        run_err("R9");
        wr(2, mk_cmd(16, 0, 1, 1, 1, 0, 0, 0, 1, 0));
        run_err("R9");

        // R13: zero burst code and zero length rejected
        wr(2, mk_cmd(16, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        run_err("R13");
        wr(2, mk_cmd(0, 0, 1, 1, 1, 0, 0, 0, 0, 0));
        run_err("R13");

        // R11 R12: stop while a burst waits for grant, write during run ignored
        cfg_all(32'h7000_0000, 32'h7100_0000, mk_cmd(64, 0, 1, 1, 1, 0, 0, 0, 0, 0), 1'b0);
        gnt_auto = 1'b0; gnt_force = 1'b0;
        begin
            int d0;
            d0 = done_cnt;
            push_bursts(32'h7000_0000, 32'h7100_0000, 8, 8, 1, 1, 0, 0, 0, "R11");
            pulse_start();
            @(negedge clk);
            chk(running && !end_flag && !cfg_err, "R10", "accepted start clears flags",
                {running, end_flag, cfg_err}, 3'b100);
            while (!bus_req) @(negedge clk);
            @(posedge clk); #1;
            stop = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0BAD_0000;
            @(posedge clk); #1;
            stop = 1'b0; cfg_we = 1'b0;
            repeat (3) @(negedge clk);
            chk(bus_req, "R11", "request held after stop", bus_req, 1);
            @(posedge clk); #1 gnt_force = 1'b1;
            @(posedge clk); #1 gnt_force = 1'b0;
            repeat (3) @(negedge clk);
            chk(!running && !bus_req && !end_flag, "R11", "idle after stop {run,req,end}",
                {running, bus_req, end_flag}, 0);
            chk(done_cnt == d0, "R11", "no done on stop", done_cnt - d0, 0);
            chk(exp_q.size() == 0, "R11", "stopped burst count", exp_q.size(), 0);
        end
        gnt_auto = 1'b1;
        push_bursts(32'h7000_0000, 32'h7100_0000, 64, 8, 1, 1, 0, 0, 0, "R12");
        run_ok("R12");

        repeat (3) @(negedge clk);
        chk(end_flag, "R10", "end_flag sticky", end_flag, 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule